// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Refresh

This block sits between a simple host request port and a 16-bit asynchronous DRAM. The DRAM has one row strobe, one column strobe per byte lane, a write enable and an output enable. The host offers one request at a time: a read or a write, a word address and, for writes, data and a byte mask. The controller splits the word address into a row part and a column part and puts them on the shared address pins one after the other. Writes are early writes, so the DRAM never drives its data pins during a write. Reads return one word with a single-cycle valid pulse.

The controller handles the DRAM's own upkeep. After reset it keeps every strobe idle for a long power-up pause. It then runs a burst of eight wake-up refreshes before it accepts any host traffic. After that a timer asks for a column-before-row refresh at a fixed interval, and a due refresh is served before any waiting host request. If the timer ever counts past its limit with no refresh started, the controller treats the array as having lost its refresh and runs the eight-refresh wake-up burst again. Every DRAM timing is a whole number of clock cycles set by a parameter.

Top module: `dram_ctl`

## Requirements
- R1: From reset and for at least PAUSE_CYC cycles after it, the row strobe and both column strobes stay high and req_ready stays low.
- R2: After the pause, exactly WAKE_N (8) refresh cycles run before req_ready is high for the first time.
- R3: If REF_LIM cycles pass after a refresh start with no new refresh started, a back-to-back burst of WAKE_N refreshes runs before the next host cycle.
- R4: Column strobe bit 0 gates data bits 7:0 and bit 1 gates bits 15:8. A write pulls low only the strobes whose req_mask bit is 1, so a mask of 00 leaves memory unchanged. A read pulls both strobes low.
- R5: In a write, dram_we_n is low for at least one cycle before the first column strobe falls, and dram_dq_oe is high while that strobe falls.
- R6: dram_oe_n is high in every cycle in which dram_we_n is low.
- R7: A read returns, one cycle after its column strobes rise, a single-cycle rsp_valid pulse. rsp_data then holds the word most recently written at that address, merged byte by byte.
- R8: A refresh pulls both column strobes low at least one cycle before the row strobe falls, with dram_we_n high.
- R9: While the host is idle, refresh cycles start every REF_INT cycles. A due refresh is served before a waiting host request.
- R10: The row part (upper ROW_W bits of req_addr) is on dram_addr in the cycle before the row strobe falls and in the cycle it falls. The column part (lower COL_W bits) is on dram_addr when the column strobes fall.
- R11: When the row strobe rises, both column strobes are high. Every strobe then stays high for at least T_RP cycles before the row strobe falls again.
- R12: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is high only while every DRAM strobe is high and no refresh is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row part on top |
| req_wdata | input | DQ_W | Write data |
| req_mask | input | DQ_W/8 | Byte lanes to write |
| rsp_valid | output | 1 | Read data pulse |
| rsp_data | output | DQ_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | DQ_W/8 | Column strobe per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DQ_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
The hardest case to reach from the ports is the overdue refresh. On a correctly run block the timer is served long before its limit, so the wake-up burst never comes back by itself. A second instance in the bench sets the limit equal to the interval and keeps req_valid high all the time. A refresh that falls due in the middle of a host cycle is then certain to overrun, and the bench records the length of each run of refreshes between host cycles. The main instance runs against a behavioural DRAM model. The model follows the strobes on every clock, stores written bytes by lane and returns read data, so address, lane and ordering errors show up as wrong read data or wrong pin events.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [3:0] {
    S_PAUSE,  // power-up wait, all strobes idle
    S_PRE,    // precharge, all strobes high
    S_IDLE,   // ready for host
    S_RSU,    // row address setup
    S_ROW,    // row strobe low, row address held
    S_COL,    // column address setup
    S_CAS,    // column strobes low
    S_RFC,    // refresh: column strobes low first
    S_RFR     // refresh: row strobe low
  } seq_st_t;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int REF_INT = 975,
  parameter int REF_LIM = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic due,
  output logic overdue
);

  localparam int CNT_W = $clog2(dram_pkg::max_i(REF_LIM, REF_INT) + 2) + 1;

  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (ack)
      cnt_n = '0;
    else if (run && (cnt < CNT_W'(REF_LIM)))
      cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= cnt_n;
  end

  assign due     = (cnt >= CNT_W'(REF_INT - 1));
  assign overdue = (cnt >= CNT_W'(REF_LIM));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  localparam int A_W  = dram_pkg::max_i(ROW_W, COL_W)
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             sel_col,
  output logic [A_W-1:0]   addr
);

  logic [A_W-1:0] row_x, col_x;

  generate
    if (ROW_W < A_W) begin : g_row_pad
      assign row_x = {{(A_W-ROW_W){1'b0}}, row};
    end else begin : g_row_full
      assign row_x = row;
    end
    if (COL_W < A_W) begin : g_col_pad
      assign col_x = {{(A_W-COL_W){1'b0}}, col};
    end else begin : g_col_full
      assign col_x = col;
    end
  endgenerate

  assign addr = sel_col ? col_x : row_x;

endmodule

// File: rtl/dram_lane_strobe.sv
module dram_lane_strobe (
  input  logic host_ph,
  input  logic ref_ph,
  input  logic is_wr,
  input  logic lane_en,
  output logic cas_n
);

  assign cas_n = ~(ref_ph | (host_ph & (~is_wr | lane_en)));

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl #(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int DQ_W      = 16,
  parameter int PAUSE_CYC = 12_500_000,
  parameter int WAKE_N    = 8,
  parameter int REF_INT   = 975,
  parameter int REF_LIM   = 1950,
  parameter int T_ASR     = 1,
  parameter int T_RAH     = 1,
  parameter int T_ASC     = 1,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 2,
  parameter int T_CSR     = 1,
  parameter int T_RASR    = 3,
  localparam int LANES    = DQ_W / 8,
  localparam int HA_W     = ROW_W + COL_W,
  localparam int A_W      = dram_pkg::max_i(ROW_W, COL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [HA_W-1:0]  req_addr,
  input  logic [DQ_W-1:0]  req_wdata,
  input  logic [LANES-1:0] req_mask,
  output logic             rsp_valid,
  output logic [DQ_W-1:0]  rsp_data,
  output logic [A_W-1:0]   dram_addr,
  output logic             dram_ras_n,
  output logic [LANES-1:0] dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_oe_n,
  output logic [DQ_W-1:0]  dram_dq_out,
  output logic             dram_dq_oe,
  input  logic [DQ_W-1:0]  dram_dq_in
);

  import dram_pkg::*;

  localparam int T_MAX = max_i(max_i(max_i(PAUSE_CYC, T_ASR), max_i(T_RAH, T_ASC)),
                               max_i(max_i(T_CAS, T_RP), max_i(T_CSR, T_RASR)));
  localparam int TMR_W = $clog2(T_MAX + 1) + 1;
  localparam int WK_W  = $clog2(WAKE_N + 1) + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  seq_st_t          st, st_n;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic [WK_W-1:0]  wake_left, wake_n, wk_base;
  logic             wr_q;
  logic [HA_W-1:0]  addr_q;
  logic [DQ_W-1:0]  wdata_q;
  logic [LANES-1:0] mask_q;
  logic             rsp_valid_q;
  logic [DQ_W-1:0]  rsp_data_q;

  logic take, ack, grab, pause_done, ref_go;
  logic ref_due, ref_over, tmr_run;

  dram_ref_timer #(
    .REF_INT(REF_INT),
    .REF_LIM(REF_LIM)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_i),
    .run    (tmr_run),
    .ack    (ack),
    .due    (ref_due),
    .overdue(ref_over)
  );

  assign tmr_run = (st != S_PAUSE);
  assign ref_go  = (wake_left != '0) || ref_due;

  // next state
  always_comb begin
    st_n = st;
    tmr_n = (tmr != '0) ? tmr - 1'b1 : tmr;
    take = 1'b0;
    ack  = 1'b0;
    grab = 1'b0;
    pause_done = 1'b0;
    unique case (st)
      S_PAUSE: if (tmr == '0) begin
        st_n = S_PRE;
        tmr_n = TMR_W'(T_RP - 1);
        pause_done = 1'b1;
      end
      S_PRE: if (tmr == '0) begin
        if (ref_go) begin
          st_n = S_RFC;
          tmr_n = TMR_W'(T_CSR - 1);
          ack = 1'b1;
        end else begin
          st_n = S_IDLE;
        end
      end
      S_IDLE: begin
        if (ref_go) begin
          st_n = S_RFC;
          tmr_n = TMR_W'(T_CSR - 1);
          ack = 1'b1;
        end else if (req_valid) begin
          st_n = S_RSU;
          tmr_n = TMR_W'(T_ASR - 1);
          take = 1'b1;
        end
      end
      S_RSU: if (tmr == '0) begin
        st_n = S_ROW;
        tmr_n = TMR_W'(T_RAH - 1);
      end
      S_ROW: if (tmr == '0) begin
        st_n = S_COL;
        tmr_n = TMR_W'(T_ASC - 1);
      end
      S_COL: if (tmr == '0) begin
        st_n = S_CAS;
        tmr_n = TMR_W'(T_CAS - 1);
      end
      S_CAS: if (tmr == '0) begin
        st_n = S_PRE;
        tmr_n = TMR_W'(T_RP - 1);
        grab = ~wr_q;
      end
      S_RFC: if (tmr == '0) begin
        st_n = S_RFR;
        tmr_n = TMR_W'(T_RASR - 1);
      end
      S_RFR: if (tmr == '0) begin
        st_n = S_PRE;
        tmr_n = TMR_W'(T_RP - 1);
      end
      default: begin
        st_n = S_PAUSE;
        tmr_n = TMR_W'(PAUSE_CYC - 1);
      end
    endcase
  end

  // wake-up refresh budget
  always_comb begin
    if (pause_done || ref_over)
      wk_base = WK_W'(WAKE_N);
    else
      wk_base = wake_left;
    if (ack)
      wake_n = (wk_base != '0) ? wk_base - 1'b1 : '0;
    else
      wake_n = wk_base;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st          <= S_PAUSE;
      tmr         <= TMR_W'(PAUSE_CYC - 1);
      wake_left   <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      st          <= st_n;
      tmr         <= tmr_n;
      wake_left   <= wake_n;
      rsp_valid_q <= grab;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (take) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)
      rsp_data_q <= '0;
    else if (grab)
      rsp_data_q <= dram_dq_in;
  end

  // DRAM pins
  logic host_ph, ref_ph, wr_ph, sel_col;

  assign host_ph = (st == S_CAS);
  assign ref_ph  = (st == S_RFC) || (st == S_RFR);
  assign sel_col = (st == S_COL) || (st == S_CAS);
  assign wr_ph   = wr_q && sel_col;

  dram_addr_mux #(
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_amux (
    .row    (addr_q[HA_W-1:COL_W]),
    .col    (addr_q[COL_W-1:0]),
    .sel_col(sel_col),
    .addr   (dram_addr)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      dram_lane_strobe u_lane (
        .host_ph(host_ph),
        .ref_ph (ref_ph),
        .is_wr  (wr_q),
        .lane_en(mask_q[g]),
        .cas_n  (dram_cas_n[g])
      );
    end
  endgenerate

  assign dram_ras_n  = ~((st == S_ROW) || (st == S_COL) || (st == S_CAS) || (st == S_RFR));
  assign dram_we_n   = ~wr_ph;
  assign dram_oe_n   = ~(~wr_q && host_ph);
  assign dram_dq_oe  = wr_ph;
  assign dram_dq_out = wdata_q;

  assign req_ready = (st == S_IDLE) && (wake_left == '0) && !ref_due;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk #(
  parameter int PAUSE_CYC = 12_500_000,
  parameter int LANES     = 2,
  parameter int A_W       = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [A_W-1:0]   dram_addr,
  input logic             dram_ras_n,
  input logic [LANES-1:0] dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_oe_n,
  input logic             dram_dq_oe
);

  localparam int CW = $clog2(PAUSE_CYC + 1) + 1;
  localparam logic [LANES-1:0] ALL_HI = '1;

  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since <= '0;
    else if (since < CW'(PAUSE_CYC))
      since <= since + 1'b1;
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since < CW'(PAUSE_CYC)) |-> (dram_ras_n && (dram_cas_n == ALL_HI) && !req_ready));

  assert_lane_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_oe_n && (dram_cas_n != ALL_HI)) |-> (dram_cas_n == '0));

  assert_early_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_we_n && ($past(dram_cas_n) == ALL_HI) && (dram_cas_n != ALL_HI))
      |-> (!$past(dram_we_n) && dram_dq_oe));

  assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n);

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_cbr_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && (dram_cas_n != ALL_HI)) |-> ((dram_cas_n == '0) && dram_we_n));

  assert_row_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && (dram_cas_n == ALL_HI)) |-> $stable(dram_addr));

  assert_ras_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (dram_cas_n == ALL_HI));

  assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && (dram_cas_n == ALL_HI) && dram_we_n));

endmodule

bind dram_ctl dram_ctl_chk #(
  .PAUSE_CYC(PAUSE_CYC),
  .LANES    (LANES),
  .A_W      (A_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .dram_addr (dram_addr),
  .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n),
  .dram_we_n (dram_we_n),
  .dram_oe_n (dram_oe_n),
  .dram_dq_oe(dram_dq_oe)
);

// File: tb/sim_dram_ctl.sv
module sim_dram_ctl;

  localparam int ROW_W = 9;
  localparam int COL_W = 9;
  localparam int PAUSE = 200;
  localparam int RINT  = 300;
  localparam int TRP   = 2;
  localparam int PAUSE1 = 50;
  localparam int RINT1  = 40;

  logic clk;
  logic rst_n;
  int   total, bad, cyc;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- main instance
  logic        valid, ready, wr, rvld;
  logic [17:0] addr;
  logic [15:0] wdata, rdata, dq_out, dq_in;
  logic [1:0]  mask, cas_n;
  logic [8:0]  a_pin;
  logic        ras_n, we_n, oe_n, dq_oe;

  dram_ctl #(
    .PAUSE_CYC(PAUSE), .REF_INT(RINT), .REF_LIM(2*RINT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(valid), .req_ready(ready),
    .req_write(wr), .req_addr(addr), .req_wdata(wdata), .req_mask(mask),
    .rsp_valid(rvld), .rsp_data(rdata), .dram_addr(a_pin),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_oe_n(oe_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
    .dram_dq_in(dq_in)
  );

  // ---------------- overdue instance: limit equals interval
  logic        ready1, rvld1, ras1_n, we1_n, oe1_n, dqoe1;
  logic [15:0] rdata1, dqo1;
  logic [1:0]  cas1_n;
  logic [8:0]  a1;

  dram_ctl #(
    .PAUSE_CYC(PAUSE1), .REF_INT(RINT1), .REF_LIM(RINT1)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(1'b1), .req_ready(ready1),
    .req_write(1'b1), .req_addr(18'h00055), .req_wdata(16'h1234), .req_mask(2'b11),
    .rsp_valid(rvld1), .rsp_data(rdata1), .dram_addr(a1),
    .dram_ras_n(ras1_n), .dram_cas_n(cas1_n), .dram_we_n(we1_n),
    .dram_oe_n(oe1_n), .dram_dq_out(dqo1), .dram_dq_oe(dqoe1),
    .dram_dq_in(16'h0000)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- expected side, built from requests
  typedef struct { bit w; int a; logic [15:0] d; logic [1:0] m; } rq_t;
  rq_t         pend_q[$];
  logic [15:0] exp_rd_q[$];
  logic [15:0] exp_mem[int];

  function automatic logic [15:0] exp_get(int a);
    return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
  endfunction

  // ---------------- behavioural DRAM model, evaluated every clock
  logic [15:0] dmem[int];
  logic        p_ras, p_we, p_rvld, seen_ready;
  logic [1:0]  p_cas;
  int          cur_key, last_rise, first_strobe, refs_before_ready;
  int          ref_t_last, ref_t_prev;
  rq_t         cur;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  initial begin
    p_ras = 1; p_cas = 2'b11; p_we = 1; p_rvld = 0; seen_ready = 0;
    first_strobe = -1; refs_before_ready = 0; last_rise = 0;
    ref_t_last = -1; ref_t_prev = -1; dq_in = 16'h0; cur_key = 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (first_strobe < 0 && (!ras_n || cas_n != 2'b11)) first_strobe = cyc;
    // row strobe falls
    if (p_ras && !ras_n) begin
      chk(cyc - last_rise >= TRP, "R11 precharge length", cyc - last_rise, TRP);
      if (cas_n != 2'b11) begin
        chk(cas_n == 2'b00 && p_cas == 2'b00 && we_n, "R8 refresh order",
            {p_cas, cas_n, we_n}, {2'b00, 2'b00, 1'b1});
        if (!seen_ready) refs_before_ready++;
        ref_t_prev = ref_t_last; ref_t_last = cyc;
      end else begin
        chk(pend_q.size() != 0, "R12 host cycle without request", 0, 1);
        if (pend_q.size() != 0) cur = pend_q.pop_front();
        chk(a_pin == 9'(cur.a >> COL_W), "R10 row address", a_pin, cur.a >> COL_W);
      end
    end
    if (!p_ras && ras_n) begin
      last_rise = cyc;
      chk(cas_n == 2'b11, "R11 strobes high at row rise", cas_n, 2'b11);
    end
    // column strobes fall in a host cycle
    if (!ras_n && p_cas == 2'b11 && cas_n != 2'b11) begin
      chk(a_pin == 9'(cur.a & 511), "R10 column address", a_pin, cur.a & 511);
      cur_key = cur.a;
      if (cur.w) begin
        chk(cas_n == ~cur.m, "R4 write lanes", cas_n, ~cur.m);
        chk(!p_we && !we_n && dq_oe, "R5 early write", {p_we, we_n, dq_oe}, 3'b001);
        if (!dmem.exists(cur_key)) dmem[cur_key] = 16'h0;
        if (!cas_n[0]) dmem[cur_key][7:0]  = dq_out[7:0];
        if (!cas_n[1]) dmem[cur_key][15:8] = dq_out[15:8];
      end else begin
        chk(cas_n == 2'b00, "R4 read lanes", cas_n, 2'b00);
      end
    end
    if (!we_n) chk(oe_n, "R6 output enable off in write", oe_n, 1);
    if (ready) chk(ras_n && cas_n == 2'b11, "R12 ready only when strobes idle",
                   {ras_n, cas_n}, 3'b111);
    if (!seen_ready && ready) seen_ready = 1;
    // read data from the model array
    if (!oe_n && !ras_n && cas_n != 2'b11)
      dq_in = dmem.exists(cur_key) ? dmem[cur_key] : 16'h0;
    else
      dq_in = 16'h0;
    // responses
    if (rvld) begin
      chk(!p_rvld, "R7 single cycle pulse", p_rvld, 0);
      chk(exp_rd_q.size() != 0, "R7 unexpected response", 0, 1);
      if (exp_rd_q.size() != 0) begin
        logic [15:0] e;
        e = exp_rd_q.pop_front();
        chk(rdata == e, "R7 read data", rdata, e);
      end
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_rvld = rvld;
  end

  // ---------------- overdue monitor on u1
  logic p_ras1, seen_r1;
  int   run1, runs1, run8, odd_run;
  initial begin p_ras1 = 1; seen_r1 = 0; run1 = 0; runs1 = 0; run8 = 0; odd_run = 0; end

  always @(negedge clk) if (rst_n) begin
    if (ready1) seen_r1 = 1;
    if (seen_r1 && p_ras1 && !ras1_n) begin
      if (cas1_n != 2'b11) run1++;
      else if (run1 > 0) begin
        runs1++;
        if (run1 == 8) run8++;
        else if (run1 != 1) odd_run = run1;
        run1 = 0;
      end
    end
    p_ras1 = ras1_n;
  end

  // ---------------- host driver
  task automatic host_req(input bit w, input int a, input logic [15:0] d, input logic [1:0] m);
    bit was_rdy;
    valid = 1; wr = w; addr = 18'(a); wdata = d; mask = m;
    do begin
      was_rdy = ready;
      @(negedge clk);
    end while (!was_rdy);
    valid = 0;
    pend_q.push_back('{w, a, d, m});
    if (w) begin
      logic [15:0] o;
      o = exp_get(a);
      if (m[0]) o[7:0]  = d[7:0];
      if (m[1]) o[15:8] = d[15:8];
      exp_mem[a] = o;
    end else begin
      exp_rd_q.push_back(exp_get(a));
    end
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((exp_rd_q.size() != 0 || pend_q.size() != 0) && n < 200) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
    chk(exp_rd_q.size() == 0, "R7 responses outstanding", exp_rd_q.size(), 0);
  endtask

  // ---------------- watchdog
  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main sequence
  initial begin
    total = 0; bad = 0;
    valid = 0; wr = 0; addr = '0; wdata = '0; mask = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n == 2'b11 && !ready && !rvld, "R1 reset state",
        {ras_n, cas_n, ready, rvld}, 5'b11100);
    rst_n = 1;

    while (!ready) @(negedge clk);
    chk(first_strobe >= PAUSE, "R1 power-up pause", first_strobe, PAUSE);
    chk(refs_before_ready == 8, "R2 wake-up refresh count", refs_before_ready, 8);

    // basic writes and reads, lane merges, address extremes
    host_req(1, 18'h00123, 16'hA1B2, 2'b11);
    host_req(1, 18'h3FFFF, 16'h5A5A, 2'b11);
    host_req(1, 18'h00000, 16'hC3D4, 2'b11);
    host_req(0, 18'h00123, 16'h0, 2'b00);
    host_req(1, 18'h00123, 16'hEEFF, 2'b01);   // R4 low lane only
    host_req(0, 18'h00123, 16'h0, 2'b00);
    host_req(1, 18'h00123, 16'h7788, 2'b10);   // R4 high lane only
    host_req(0, 18'h00123, 16'h0, 2'b00);
    host_req(1, 18'h3FFFF, 16'h9999, 2'b00);   // R4 empty mask: no change
    host_req(0, 18'h3FFFF, 16'h0, 2'b00);
    host_req(0, 18'h00000, 16'h0, 2'b00);
    drain();

    // back-to-back traffic with varied rows and columns
    for (int i = 0; i < 24; i++)
      host_req(1, (i * 18'h0A41) & 18'h3FFFF, 16'(i * 16'h1357 + 3), 2'(i % 3 + 1));
    for (int i = 0; i < 24; i++)
      host_req(0, (i * 18'h0A41) & 18'h3FFFF, 16'h0, 2'b00);
    drain();

    // idle: periodic refresh interval (R9)
    repeat (2 * RINT + 50) @(negedge clk);
    chk(ref_t_last - ref_t_prev == RINT, "R9 idle refresh interval",
        ref_t_last - ref_t_prev, RINT);

    // overdue handling and refresh priority under constant traffic (R3, R9)
    chk(run8 > 0, "R3 wake-up burst after overdue refresh", run8, 1);
    chk(odd_run == 0, "R3 refresh run length", odd_run, 8);
    chk(runs1 >= 2, "R9 refresh served under constant requests", runs1, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule